// File: doc/BRIEF.md
# Command-Stream I2C Master

This block is an I2C bus master that takes all of its instructions from a stream of 10-bit command words. Each word carries a data byte and two flags. The flags ask for a START condition before the byte or a STOP condition after the byte or transfer. Software or an upstream engine only pushes words. No per-transfer control writes are needed, because address phases, byte counts, repeated starts and the final STOP are all encoded in the stream.

Command words enter through a valid/ready port backed by a 16-entry queue. The word is taken on a clock edge where both `tx_valid` and `tx_ready` are high. `tx_ready` drops only while the queue is full, and the producer must then hold the word stable.

Bytes read from a slave leave through a second valid/ready port backed by another 16-entry queue. A byte is consumed on an edge where `rx_valid` and `rx_ready` are both high. When the consumer stops taking bytes and the queue fills, the master stalls the bus with SCL held low before the next byte, so no data is lost.

SCL and SDA are open-drain lines. The block only pulls them low through output enables and samples them back through two-flop synchronizers.

Top module: `i2c_dyn_master`

## Requirements
- R1: A command word uses bits 7:0 as data, bit 8 as the START flag and bit 9 as the STOP flag. A word with bit 8 set generates a START (or repeated START) and then sends its byte as the address byte. Bit 0 of that byte is 1 for a read and 0 for a write.
- R2: After a write address, each later word without a START flag is sent as a data byte, MSB first, with the slave's ACK sampled on the ninth clock. A STOP flag on a data word produces a STOP after that byte is acknowledged.
- R3: A write address word with both START and STOP flags acts as a probe: START, address byte, acknowledge clock, STOP, and no data bytes.
- R4: After a read address is acknowledged, the next word's bits 7:0 give a byte count. That many bytes are received MSB first and queued in order. The master ACKs every byte except the last, which it NACKs.
- R5: If the byte-count word carries the STOP flag, a STOP follows the last received byte. Otherwise the bus stays held with SCL low, and the next START word produces a repeated START without an intervening STOP.
- R6: A NACK on an address byte or a data byte sets `tx_err`, discards every word still queued for transmit, and ends the transfer with a STOP. `tx_err` and `bus_idle_irq` clear when the next START word is taken.
- R7: `bus_busy` is high from the moment a START word is taken until the STOP completes. `bus_idle_irq` is set when the STOP completes. While `bus_busy` is low, SCL is released.
- R8: If the transmit queue runs empty during a write and no STOP has been requested, SCL is held low and the bus stays busy until the next word arrives. Transmission then resumes without a new START.
- R9: Both queues hold 16 entries. `tx_level` and `rx_level` are zero-based: a value N with the matching empty flag low means N+1 entries are held. When the receive queue is full, the master holds SCL low before the next byte until space appears.
- R10: SDA changes only while SCL is low, except at START and STOP conditions. Each SCL high phase lasts at least two quarter periods of `QTR_CLKS` system clocks.
- R11: A word without the START flag that arrives while the bus is free is discarded, and no bus activity follows.
- R12: After reset, both lines are released, both queues are empty, and `bus_busy`, `tx_err` and `bus_idle_irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_valid | input | 1 | Command word offered |
| tx_data | input | 10 | Command word: STOP flag, START flag, byte |
| tx_ready | output | 1 | Command queue can accept a word |
| rx_valid | output | 1 | Received byte available |
| rx_data | output | 8 | Oldest received byte |
| rx_ready | input | 1 | Consumer takes the received byte |
| tx_level | output | 4 | Command queue occupancy, zero-based |
| tx_empty | output | 1 | Command queue holds nothing |
| rx_level | output | 4 | Receive queue occupancy, zero-based |
| rx_empty | output | 1 | Receive queue holds nothing |
| bus_busy | output | 1 | Transfer in progress on the bus |
| tx_err | output | 1 | Address or data byte was not acknowledged |
| bus_idle_irq | output | 1 | Set when a STOP has released the bus |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low when high |
| sda_oe | output | 1 | Pull SDA low when high |

## Verification
A corrupted sequencer state shows up on the bus within one byte time, about 36 quarter periods. The slave then sees an extra or missing START/STOP, a byte out of order, or an ACK where a NACK belongs. A bit-engine phase error shows up within a single SCL period as SDA moving while SCL is high, which the slave reads as a stray condition. Queue pointer or count faults appear at the occupancy ports and the receive stream as soon as the next word or byte crosses them. A dropped NACK leaves `tx_err` low and lets flushed words reach the bus.

// File: rtl/i2cseq_pkg.sv
package i2cseq_pkg;

  typedef enum logic [1:0] {
    BC_START = 2'd0,
    BC_STOP  = 2'd1,
    BC_BIT   = 2'd2
  } bit_cmd_e;

  typedef struct packed {
    logic       stop;
    logic       start;
    logic [7:0] data;
  } cmd_word_t;

  typedef enum logic [2:0] {
    ST_FETCH = 3'd0,
    ST_START = 3'd1,
    ST_TXB   = 3'd2,
    ST_TXACK = 3'd3,
    ST_CNT   = 3'd4,
    ST_RXB   = 3'd5,
    ST_RXACK = 3'd6,
    ST_STOP  = 3'd7
  } seq_state_e;

endpackage

// File: rtl/i2cseq_fifo.sv
module i2cseq_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush,
  input  logic                         in_valid,
  output logic                         in_ready,
  input  logic [W-1:0]                 in_data,
  output logic                         out_valid,
  input  logic                         out_ready,
  output logic [W-1:0]                 out_data,
  output logic [$clog2(DEPTH+1)-1:0]   count
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          push, pop;

  assign in_ready  = (count != CW'(DEPTH));
  assign out_valid = (count != '0);
  assign out_data  = mem[rd_ptr];
  assign push      = in_valid && in_ready;
  assign pop       = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + AW'(1);
      if (pop)  rd_ptr <= rd_ptr + AW'(1);
      case ({push, pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n) assert_fill_bound_R9: assert (count <= CW'(DEPTH))
      else $error("queue count beyond depth");
  end

endmodule

// File: rtl/i2cseq_bit_engine.sv
module i2cseq_bit_engine
  import i2cseq_pkg::*;
#(
  parameter int QTR_CLKS = 250
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cmd_valid,
  input  bit_cmd_e cmd,
  input  logic     cmd_bit,
  output logic     ready,
  output logic     done,
  output logic     rx_bit,
  input  logic     scl_i,
  input  logic     sda_i,
  output logic     scl_oe,
  output logic     sda_oe
);
  localparam int QW = (QTR_CLKS > 1) ? $clog2(QTR_CLKS) : 1;

  logic          busy;
  bit_cmd_e      cur;
  logic          bitv;
  logic [1:0]    ph;
  logic [QW-1:0] qcnt;
  logic [1:0]    scl_s, sda_s;
  logic [1:0]    start_ph;

  // {scl pull, sda pull} for each quarter of a command
  function automatic logic [1:0] drive_pat(bit_cmd_e c, logic [1:0] p, logic b);
    case (c)
      BC_START: case (p)
        2'd0:    drive_pat = 2'b10;
        2'd1:    drive_pat = 2'b00;
        2'd2:    drive_pat = 2'b01;
        default: drive_pat = 2'b11;
      endcase
      BC_STOP: case (p)
        2'd0:    drive_pat = 2'b11;
        2'd3:    drive_pat = 2'b00;
        default: drive_pat = 2'b01;
      endcase
      default: drive_pat = {(p == 2'd0) || (p == 2'd3), ~b};
    endcase
  endfunction

  assign ready    = !busy;
  // from a free bus, skip the quarter that would pull SCL low
  assign start_ph = (cmd == BC_START && !scl_oe) ? 2'd1 : 2'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cur    <= BC_BIT;
      bitv   <= 1'b1;
      ph     <= 2'd0;
      qcnt   <= '0;
      scl_s  <= 2'b11;
      sda_s  <= 2'b11;
      scl_oe <= 1'b0;
      sda_oe <= 1'b0;
      done   <= 1'b0;
      rx_bit <= 1'b1;
    end else begin
      scl_s <= {scl_s[0], scl_i};
      sda_s <= {sda_s[0], sda_i};
      done  <= 1'b0;
      if (!busy) begin
        if (cmd_valid) begin
          busy             <= 1'b1;
          cur              <= cmd;
          bitv             <= cmd_bit;
          ph               <= start_ph;
          qcnt             <= '0;
          {scl_oe, sda_oe} <= drive_pat(cmd, start_ph, cmd_bit);
        end
      end else if (ph == 2'd1 && !scl_s[1]) begin
        qcnt <= '0;  // wait for SCL to be seen high
      end else if (qcnt == QW'(QTR_CLKS - 1)) begin
        qcnt <= '0;
        if (ph == 2'd2) rx_bit <= sda_s[1];
        if (ph == 2'd3) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          ph               <= ph + 2'd1;
          {scl_oe, sda_oe} <= drive_pat(cur, ph + 2'd1, bitv);
        end
      end else begin
        qcnt <= qcnt + QW'(1);
      end
    end
  end

  assert_sda_moves_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_oe) && !scl_oe && !$past(scl_oe)) |-> (cur != BC_BIT))
    else $error("SDA moved while SCL high during a data bit");

endmodule

// File: rtl/i2c_dyn_master.sv
module i2c_dyn_master
  import i2cseq_pkg::*;
#(
  parameter int QTR_CLKS   = 250,
  parameter int FIFO_DEPTH = 16
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            tx_valid,
  input  logic [9:0]                      tx_data,
  output logic                            tx_ready,
  output logic                            rx_valid,
  output logic [7:0]                      rx_data,
  input  logic                            rx_ready,
  output logic [$clog2(FIFO_DEPTH)-1:0]   tx_level,
  output logic                            tx_empty,
  output logic [$clog2(FIFO_DEPTH)-1:0]   rx_level,
  output logic                            rx_empty,
  output logic                            bus_busy,
  output logic                            tx_err,
  output logic                            bus_idle_irq,
  input  logic                            scl_i,
  input  logic                            sda_i,
  output logic                            scl_oe,
  output logic                            sda_oe
);
  localparam int LVL_W = $clog2(FIFO_DEPTH);
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

  seq_state_e       state;
  logic             issued;
  logic [7:0]       sh;
  logic [2:0]       bitcnt;
  logic [7:0]       remain;
  logic             rd_mode, is_addr, stop_after;

  logic             txq_valid, txq_pop;
  logic [9:0]       txq_data;
  logic [CNT_W-1:0] txq_cnt, rxq_cnt;
  logic             rx_wr, rxq_room, nack_flush;
  logic [7:0]       rx_byte;
  cmd_word_t        w;

  logic             eng_valid, eng_ready, eng_done, eng_rx, eng_bit;
  bit_cmd_e         eng_cmd;

  assign w = cmd_word_t'(txq_data);

  i2cseq_fifo #(.W(10), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk, .rst_n, .flush(nack_flush),
    .in_valid(tx_valid), .in_ready(tx_ready), .in_data(tx_data),
    .out_valid(txq_valid), .out_ready(txq_pop), .out_data(txq_data),
    .count(txq_cnt));

  i2cseq_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk, .rst_n, .flush(1'b0),
    .in_valid(rx_wr), .in_ready(rxq_room), .in_data(rx_byte),
    .out_valid(rx_valid), .out_ready(rx_ready), .out_data(rx_data),
    .count(rxq_cnt));

  i2cseq_bit_engine #(.QTR_CLKS(QTR_CLKS)) u_eng (
    .clk, .rst_n, .cmd_valid(eng_valid), .cmd(eng_cmd), .cmd_bit(eng_bit),
    .ready(eng_ready), .done(eng_done), .rx_bit(eng_rx),
    .scl_i, .sda_i, .scl_oe, .sda_oe);

  assign tx_empty   = (txq_cnt == '0);
  assign rx_empty   = (rxq_cnt == '0);
  assign tx_level   = tx_empty ? '0 : LVL_W'(txq_cnt - CNT_W'(1));
  assign rx_level   = rx_empty ? '0 : LVL_W'(rxq_cnt - CNT_W'(1));

  assign txq_pop    = txq_valid && (state == ST_FETCH || state == ST_CNT);
  assign nack_flush = (state == ST_TXACK) && eng_done && eng_rx;
  assign rx_wr      = (state == ST_RXB) && eng_done && (bitcnt == 3'd7);
  assign rx_byte    = {sh[6:0], eng_rx};

  always_comb begin
    eng_valid = 1'b0;
    eng_cmd   = BC_BIT;
    eng_bit   = 1'b1;
    if (!issued) begin
      case (state)
        ST_START: begin eng_valid = 1'b1; eng_cmd = BC_START; end
        ST_TXB:   begin eng_valid = 1'b1; eng_bit = sh[7]; end
        ST_TXACK: eng_valid = 1'b1;
        ST_RXB:   eng_valid = (bitcnt != 3'd0) || rxq_room;
        ST_RXACK: begin eng_valid = 1'b1; eng_bit = (remain == 8'd1); end
        ST_STOP:  begin eng_valid = 1'b1; eng_cmd = BC_STOP; end
        default:  eng_valid = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_FETCH;
      issued       <= 1'b0;
      sh           <= '0;
      bitcnt       <= '0;
      remain       <= '0;
      rd_mode      <= 1'b0;
      is_addr      <= 1'b0;
      stop_after   <= 1'b0;
      bus_busy     <= 1'b0;
      tx_err       <= 1'b0;
      bus_idle_irq <= 1'b0;
    end else begin
      if (eng_valid && eng_ready) issued <= 1'b1;
      if (eng_done)               issued <= 1'b0;
      case (state)
        ST_FETCH: if (txq_valid) begin
          if (w.start) begin
            sh           <= w.data;
            rd_mode      <= w.data[0];
            is_addr      <= 1'b1;
            stop_after   <= w.stop;
            tx_err       <= 1'b0;
            bus_idle_irq <= 1'b0;
            bus_busy     <= 1'b1;
            state        <= ST_START;
          end else if (bus_busy && !rd_mode) begin
            sh         <= w.data;
            is_addr    <= 1'b0;
            stop_after <= w.stop;
            bitcnt     <= '0;
            state      <= ST_TXB;
          end
        end
        ST_START: if (eng_done) begin
          bitcnt <= '0;
          state  <= ST_TXB;
        end
        ST_TXB: if (eng_done) begin
          sh     <= {sh[6:0], 1'b0};
          bitcnt <= bitcnt + 3'd1;
          if (bitcnt == 3'd7) state <= ST_TXACK;
        end
        ST_TXACK: if (eng_done) begin
          if (eng_rx) begin
            tx_err <= 1'b1;
            state  <= ST_STOP;
          end else if (is_addr && rd_mode) begin
            state <= ST_CNT;
          end else begin
            state <= stop_after ? ST_STOP : ST_FETCH;
          end
        end
        ST_CNT: if (txq_valid) begin
          remain     <= w.data;
          stop_after <= w.stop;
          bitcnt     <= '0;
          if (w.data == 8'd0) state <= w.stop ? ST_STOP : ST_FETCH;
          else                state <= ST_RXB;
        end
        ST_RXB: if (eng_done) begin
          sh     <= rx_byte;
          bitcnt <= bitcnt + 3'd1;
          if (bitcnt == 3'd7) state <= ST_RXACK;
        end
        ST_RXACK: if (eng_done) begin
          remain <= remain - 8'd1;
          bitcnt <= '0;
          if (remain == 8'd1) state <= stop_after ? ST_STOP : ST_FETCH;
          else                state <= ST_RXB;
        end
        default: if (eng_done) begin
          bus_busy     <= 1'b0;
          bus_idle_irq <= 1'b1;
          state        <= ST_FETCH;
        end
      endcase
    end
  end

  assert_err_from_nack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_err) |-> $past(state == ST_TXACK && eng_done && eng_rx))
    else $error("error flag without a sampled NACK");

  assert_free_bus_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_busy |-> !scl_oe)
    else $error("SCL pulled while bus not busy");

  assert_rx_push_room_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_wr |-> rxq_room)
    else $error("received byte pushed into full queue");

  assert_hold_only_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FETCH && scl_oe) |-> bus_busy)
    else $error("SCL held without an open transfer");

endmodule

// File: tb/i2c_dyn_master_bench.sv
module i2c_dyn_master_bench;
  localparam int QTR = 4;
  localparam int EV_S = 256, EV_P = 512, EV_A = 1024;
  localparam logic [9:0] F_ST = 10'h100, F_SP = 10'h200;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n, tx_valid, tx_ready, rx_valid, rx_ready;
  logic [9:0] tx_data;
  logic [7:0] rx_data;
  logic [3:0] tx_level, rx_level;
  logic       tx_empty, rx_empty, bus_busy, tx_err, bus_idle_irq;
  logic       scl_i, sda_i, scl_oe, sda_oe;

  i2c_dyn_master #(.QTR_CLKS(QTR), .FIFO_DEPTH(16)) u_i2c_dyn_master (
    .clk, .rst_n, .tx_valid, .tx_data, .tx_ready, .rx_valid, .rx_data,
    .rx_ready, .tx_level, .tx_empty, .rx_level, .rx_empty, .bus_busy,
    .tx_err, .bus_idle_irq, .scl_i, .sda_i, .scl_oe, .sda_oe);

  int n_chk = 0, n_fail = 0;
  int exp_ev[$];
  logic [7:0] exp_rx[$];
  logic [7:0] rd_model = 8'h30;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic note_ev(input int v);
    int e;
    if (exp_ev.size() == 0) chk(1'b0, "R2 unexpected bus event", v, -1);
    else begin
      e = exp_ev.pop_front();
      chk(v == e, "R2 bus event order (R10 no stray condition)", v, e);
    end
  endtask

  // open-drain lines and slave model (address 0x50)
  logic s_pull = 1'b0;
  wire scl_line = !(scl_oe === 1'b1);
  wire sda_line = !((sda_oe === 1'b1) || s_pull);
  assign scl_i = scl_line;
  assign sda_i = sda_line;

  int         cnt = 0;
  bit         ack_ph = 0, first = 0, tx_dir = 0, addressed = 0, mack = 0;
  logic [7:0] rbyte = 8'h00, obyte = 8'h00, rd_next = 8'h30;

  always @(negedge sda_line) if (rst_n === 1'b1 && scl_line) begin
    note_ev(EV_S);
    cnt = 0; ack_ph = 0; first = 1; tx_dir = 0; addressed = 0; s_pull = 1'b0;
  end

  always @(posedge sda_line) if (rst_n === 1'b1 && scl_line) begin
    note_ev(EV_P);
    cnt = 0; ack_ph = 0; first = 0; tx_dir = 0; addressed = 0; s_pull = 1'b0;
  end

  always @(posedge scl_line) if (rst_n === 1'b1) begin
    if (!ack_ph) begin
      rbyte = {rbyte[6:0], sda_line};
      cnt++;
    end else if (tx_dir) begin
      mack = sda_line;
      note_ev(EV_A + int'(mack));
    end
  end

  always @(negedge scl_line) if (rst_n === 1'b1) begin
    if (!ack_ph && cnt == 8) begin
      ack_ph = 1;
      if (tx_dir) s_pull = 1'b0;
      else begin
        note_ev(int'(rbyte));
        if (first) addressed = (rbyte[7:1] == 7'h50);
        s_pull = first ? addressed : (addressed && rbyte != 8'hEE);
      end
    end else if (ack_ph) begin
      ack_ph = 0; cnt = 0;
      if (first) begin
        first = 0;
        tx_dir = addressed && rbyte[0];
        if (tx_dir) begin obyte = rd_next; rd_next++; end
      end else if (tx_dir) begin
        if (!mack) begin obyte = rd_next; rd_next++; end
        else tx_dir = 0;
      end
      s_pull = tx_dir ? !obyte[7] : 1'b0;
    end else if (tx_dir && cnt < 8) begin
      s_pull = !obyte[7-cnt];
    end
  end

  // receive-stream monitor
  always @(negedge clk) if (rst_n === 1'b1 && rx_valid && rx_ready) begin
    if (exp_rx.size() == 0) chk(1'b0, "R4 unexpected received byte", rx_data, -1);
    else begin
      logic [7:0] e;
      e = exp_rx.pop_front();
      chk(rx_data == e, "R4 received byte order", rx_data, e);
    end
  end

  // SCL high time tracking
  int hi_cnt = 0, min_hi = 1000000;
  always @(posedge clk) begin
    if (scl_line) hi_cnt++;
    else begin
      if (hi_cnt > 0 && hi_cnt < min_hi) min_hi = hi_cnt;
      hi_cnt = 0;
    end
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  task automatic push(input logic [9:0] wd);
    @(negedge clk);
    tx_valid = 1'b1;
    tx_data  = wd;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic ex(input int v);
    exp_ev.push_back(v);
  endtask

  task automatic ex_rd(input int n, input bit last_stop);
    for (int i = 0; i < n; i++) begin
      ex(EV_A + ((i == n - 1) ? 1 : 0));
      exp_rx.push_back(rd_model);
      rd_model++;
    end
    if (last_stop) ex(EV_P);
  endtask

  task automatic wait_idle(input string tag);
    for (int i = 0; i < 40000; i++) begin
      @(negedge clk);
      if (exp_ev.size() == 0 && exp_rx.size() == 0 && !bus_busy && tx_empty) break;
    end
    repeat (20) @(negedge clk);
    chk(exp_ev.size() == 0 && exp_rx.size() == 0, tag, exp_ev.size(), 0);
  endtask

  initial begin
    rst_n = 1'b0; tx_valid = 1'b0; tx_data = '0; rx_ready = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk(!scl_oe && !sda_oe, "R12 lines released", {scl_oe, sda_oe}, 0);
    chk(tx_empty && rx_empty && tx_level == 0, "R12 queues empty", {tx_empty, rx_empty}, 3);
    chk(!bus_busy && !tx_err && !bus_idle_irq, "R12 status clear", {bus_busy, tx_err, bus_idle_irq}, 0);

    // R11 stray data word on a free bus
    push(10'h055);
    repeat (60) @(negedge clk);
    chk(tx_empty && !bus_busy && !scl_oe, "R11 word dropped, bus quiet", {tx_empty, bus_busy}, 2);

    // R1 R2 R9 write of five bytes
    ex(EV_S); ex(8'hA0); ex(8'h11); ex(8'h22); ex(8'h33); ex(8'h44); ex(8'h55); ex(EV_P);
    push(F_ST | 10'h0A0);
    push(10'h011); push(10'h022); push(10'h033); push(10'h044);
    push(F_SP | 10'h055);
    chk(tx_level == 4 && !tx_empty, "R9 zero-based tx level", tx_level, 4);
    chk(bus_busy, "R7 busy during transfer", bus_busy, 1);
    wait_idle("R2 write sequence complete");
    chk(!bus_busy && bus_idle_irq, "R7 idle flag after STOP", {bus_busy, bus_idle_irq}, 1);

    // R3 probe of present slave
    ex(EV_S); ex(8'hA0); ex(EV_P);
    push(F_ST | F_SP | 10'h0A0);
    wait_idle("R3 probe sequence");
    chk(!tx_err, "R3 probe acknowledged", tx_err, 0);

    // R6 probe of absent slave
    ex(EV_S); ex(8'h66); ex(EV_P);
    push(F_ST | F_SP | 10'h066);
    wait_idle("R6 address NACK ends with STOP");
    chk(tx_err && bus_idle_irq, "R6 address NACK flag", {tx_err, bus_idle_irq}, 3);

    // R6 data NACK flushes the queue
    ex(EV_S); ex(8'hA0); ex(8'hEE); ex(EV_P);
    push(F_ST | 10'h0A0);
    repeat (5) @(negedge clk);
    chk(!tx_err && !bus_idle_irq, "R6 flags cleared by START word", {tx_err, bus_idle_irq}, 0);
    push(10'h0EE);
    push(F_SP | 10'h077);
    wait_idle("R6 data NACK, queued word discarded");
    chk(tx_err && tx_empty, "R6 data NACK flag and flush", {tx_err, tx_empty}, 3);

    // R4 R5 read of three bytes with STOP
    ex(EV_S); ex(8'hA1); ex_rd(3, 1'b1);
    push(F_ST | 10'h0A1);
    push(F_SP | 10'h003);
    wait_idle("R4 read ACK/NACK pattern");

    // R5 repeated start: write then read
    ex(EV_S); ex(8'hA0); ex(8'h01); ex(EV_S); ex(8'hA1); ex_rd(2, 1'b1);
    push(F_ST | 10'h0A0);
    push(10'h001);
    push(F_ST | 10'h0A1);
    push(F_SP | 10'h002);
    wait_idle("R5 repeated start sequence");

    // R5 read without STOP holds the bus
    ex(EV_S); ex(8'hA1); ex_rd(1, 1'b0);
    push(F_ST | 10'h0A1);
    push(10'h001);
    repeat (600) @(negedge clk);
    chk(bus_busy && scl_oe && exp_ev.size() == 0, "R5 bus held after read", {bus_busy, scl_oe}, 3);
    ex(EV_S); ex(8'hA0); ex(EV_P);
    push(F_ST | F_SP | 10'h0A0);
    wait_idle("R5 repeated start after held read");

    // R8 write underrun holds SCL
    ex(EV_S); ex(8'hA0); ex(8'h33);
    push(F_ST | 10'h0A0);
    push(10'h033);
    repeat (600) @(negedge clk);
    chk(bus_busy && scl_oe && exp_ev.size() == 0, "R8 SCL held on empty queue", {bus_busy, scl_oe}, 3);
    ex(8'h44); ex(EV_P);
    push(F_SP | 10'h044);
    wait_idle("R8 write resumes without new START");

    // R9 receive back-pressure
    @(posedge clk); #1 rx_ready = 1'b0;
    ex(EV_S); ex(8'hA1); ex_rd(20, 1'b1);
    push(F_ST | 10'h0A1);
    push(F_SP | 10'd20);
    repeat (7000) @(negedge clk);
    chk(rx_level == 15 && !rx_empty, "R9 rx queue full, zero-based level", rx_level, 15);
    chk(scl_oe && bus_busy, "R9 SCL held while rx full", {scl_oe, bus_busy}, 3);
    @(posedge clk); #1 rx_ready = 1'b1;
    wait_idle("R9 read completes after drain");
    chk(rx_empty, "R9 rx queue drained", rx_empty, 1);

    chk(min_hi >= 2 * QTR, "R10 SCL high time", min_hi, 2 * QTR);
    summary();
  end
endmodule